// File: doc/BRIEF.md
# USB OUT Endpoint Handshake Controller

This block sits between a USB serial interface engine and a microcontroller and serves one OUT endpoint. It keeps the endpoint's configuration byte and, each time the serial engine presents a received packet, decides the handshake to return. It picks the X or Y packet buffer for the payload, checks the data PID against the expected data toggle, and flags a one-cycle interrupt to the microcontroller. All results are registered and appear on the cycle after the packet strobe.

The configuration byte has two meanings. Bit 6 selects the mode. In bulk/control/interrupt mode the byte holds enable, data toggle, double-buffer, stall and interrupt-enable bits. In isochronous mode bit 5 becomes a sticky overflow flag and bits 4:0 give the bytes per audio sample. Control endpoints get two extra rules: a setup stage is always taken, even when the endpoint is stalled, and a data stage longer than the remaining expected length stalls the endpoint by itself. The microcontroller reads and writes the whole byte through a simple strobe-and-data port.

Top module: `usb_out_ep_ctrl`

## Requirements
- R1: After reset the configuration reads 0x00, `hs_valid`, `rx_commit` and `irq` are low, and `iso_sample_bytes` is 0.
- R2: A packet that reaches the endpoint while bit 7 (enable) is 0 gets no handshake and no commit, and leaves the configuration unchanged.
- R3: In non-isochronous mode with bit 3 (stall) set, a packet gets handshake code 3 (STALL) and no commit. On a control endpoint a setup packet is still ACKed (code 1), committed to buffer X, sets the toggle bit 5 to 1 and raises `irq` when bit 2 is set.
- R4: In non-isochronous mode, a packet whose PID (`pkt_data1`) equals toggle bit 5 is ACKed (code 1) and committed, bit 5 flips, and `irq` pulses when bit 2 is set. All of these appear one cycle after `pkt_valid`.
- R5: A packet whose PID differs from bit 5 is ACKed but not committed. Bit 5 keeps its value and `irq` stays low.
- R6: When the selected buffer is full, the packet gets code 2 (NAK). There is no commit and no change to the toggle.
- R7: With bit 4 (double buffer) set, accepted packets alternate between buffer X (`rx_buf_y`=0) and buffer Y (`rx_buf_y`=1), starting with X. With bit 4 clear, every packet goes to X.
- R8: On a control endpoint, a non-setup packet with `pkt_len` > `ctrl_remain` gets STALL, bit 3 is set, and `irq` pulses whatever the value of bit 2. `pkt_len` = `ctrl_remain` is accepted normally.
- R9: In isochronous mode (bits 7:6 = 11) no handshake is ever given. Packets are committed alternately to X and Y, starting with X, and `irq` stays low.
- R10: In isochronous mode, a packet whose target buffer is full sets bit 5 (overflow) and is not committed, and the buffer choice does not advance. A write of 0 to bit 5 clears it. A write of 1 cannot set it. When a clearing write and an overflow happen in the same cycle, the flag ends up set.
- R11: In isochronous mode `iso_sample_bytes` equals bits 4:0 plus one (0x00 gives 1, 0x1F gives 32). In the other mode it is 0.
- R12: In non-isochronous mode bits 1:0 always read as 0.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst | input | 1 | Synchronous active-high reset |
| cfg_wr | input | 1 | Configuration write strobe |
| cfg_wdata | input | 8 | Configuration write data |
| cfg_rdata | output | 8 | Configuration read data |
| pkt_valid | input | 1 | One-cycle strobe: a packet for this endpoint was received |
| pkt_setup | input | 1 | Packet belongs to a setup stage |
| pkt_data1 | input | 1 | Packet PID is DATA1 (0 means DATA0) |
| pkt_len | input | LEN_W | Payload length in bytes |
| ctrl_remain | input | LEN_W | Bytes still expected in the current control write |
| buf_full_x | input | 1 | Buffer X holds unread data |
| buf_full_y | input | 1 | Buffer Y holds unread data |
| hs_valid | output | 1 | A handshake is to be sent |
| hs_code | output | 2 | 1 ACK, 2 NAK, 3 STALL, 0 none |
| rx_commit | output | 1 | Payload is kept in the chosen buffer |
| rx_buf_y | output | 1 | Chosen buffer: 0 X, 1 Y |
| irq | output | 1 | One-cycle interrupt pulse |
| iso_sample_bytes | output | 6 | Decoded bytes per sample |

## Verification
The bound checker watches these properties on every cycle: isochronous and disabled endpoints stay silent, stalled non-setup packets get STALL, every handshake follows a packet strobe, single-buffer commits always land in X, non-isochronous commits are always ACKed, and the overflow flag does not drop without a write. The toggle sequence, the PID-mismatch discard, the X/Y alternation order, the overrun boundary and the outcome of a clearing write that meets an overflow in the same cycle depend on history. Only the bench's ordered scenarios show these.

// File: rtl/oep_pkg.sv
package oep_pkg;

    typedef enum logic [1:0] {
        HS_NONE  = 2'd0,
        HS_ACK   = 2'd1,
        HS_NAK   = 2'd2,
        HS_STALL = 2'd3
    } hs_e;

    // configuration byte, field names neutral to mode
    typedef struct packed {
        logic       en;
        logic       iso;
        logic       b5;     // toggle or overflow
        logic       b4;     // double buffer or bps[4]
        logic       b3;     // stall or bps[3]
        logic       b2;     // irq enable or bps[2]
        logic [1:0] lo;     // reserved or bps[1:0]
    } cfg_t;

    typedef struct packed {
        hs_e  code;
        logic commit;
        logic buf_y;
        logic irq;
        logic tog_flip;
        logic tog_set;
        logic stall_set;
        logic ovf_set;
        logic adv_nb;
        logic adv_iso;
    } dec_t;

    localparam dec_t DEC_IDLE = '{code: HS_NONE, default: 1'b0};

    function automatic logic [4:0] bps_field(cfg_t c);
        return {c.b4, c.b3, c.b2, c.lo};
    endfunction

    function automatic logic [7:0] cfg_view(cfg_t c);
        logic [7:0] v;
        v = c;
        if (!c.iso) v[1:0] = 2'b00;
        return v;
    endfunction

endpackage

// File: rtl/oep_decide.sv
module oep_decide
    import oep_pkg::*;
#(
    parameter int  LEN_W   = 8,
    parameter bit  IS_CTRL = 1'b1,
    parameter bit  ISO_ALT = 1'b1
) (
    input  cfg_t             cfg,
    input  logic             pkt_valid,
    input  logic             pkt_setup,
    input  logic             pkt_data1,
    input  logic [LEN_W-1:0] pkt_len,
    input  logic [LEN_W-1:0] ctrl_remain,
    input  logic             buf_full_x,
    input  logic             buf_full_y,
    input  logic             nb_ptr,
    input  logic             iso_ptr,
    output dec_t             dec
);

    logic iso_tgt;
    logic nb_tgt;
    logic overrun;

    assign iso_tgt = ISO_ALT ? iso_ptr : 1'b0;
    assign nb_tgt  = cfg.b4 ? nb_ptr : 1'b0;
    assign overrun = IS_CTRL && (pkt_len > ctrl_remain);

    always_comb begin
        dec = DEC_IDLE;
        if (pkt_valid && cfg.en) begin
            if (cfg.iso) begin
                if (iso_tgt ? buf_full_y : buf_full_x) begin
                    dec.ovf_set = 1'b1;
                end else begin
                    dec.commit  = 1'b1;
                    dec.buf_y   = iso_tgt;
                    dec.adv_iso = ISO_ALT;
                end
            end else if (IS_CTRL && pkt_setup) begin
                dec.code    = HS_ACK;
                dec.commit  = 1'b1;
                dec.tog_set = 1'b1;
                dec.irq     = cfg.b2;
            end else if (cfg.b3) begin
                dec.code = HS_STALL;
            end else if (overrun) begin
                dec.code      = HS_STALL;
                dec.stall_set = 1'b1;
                dec.irq       = 1'b1;
            end else if (nb_tgt ? buf_full_y : buf_full_x) begin
                dec.code = HS_NAK;
            end else begin
                dec.code = HS_ACK;
                if (pkt_data1 == cfg.b5) begin
                    dec.commit   = 1'b1;
                    dec.buf_y    = nb_tgt;
                    dec.tog_flip = 1'b1;
                    dec.adv_nb   = cfg.b4;
                    dec.irq      = cfg.b2;
                end
            end
        end
    end

endmodule

// File: rtl/oep_cfg_reg.sv
module oep_cfg_reg
    import oep_pkg::*;
(
    input  logic       clk,
    input  logic       rst,
    input  logic       wr,
    input  logic [7:0] wdata,
    input  dec_t       dec,
    output cfg_t       cfg_q
);

    cfg_t nxt;

    always_comb begin
        nxt = cfg_q;
        if (wr) begin
            nxt = cfg_t'(wdata);
            // isochronous flag bit: software may only clear it
            if (wdata[6]) nxt.b5 = cfg_q.b5 & wdata[5];
        end
        if (dec.tog_flip)  nxt.b5 = ~nxt.b5;
        if (dec.tog_set)   nxt.b5 = 1'b1;
        if (dec.stall_set) nxt.b3 = 1'b1;
        if (dec.ovf_set)   nxt.b5 = 1'b1;
    end

    always_ff @(posedge clk) begin
        if (rst) cfg_q <= '0;
        else     cfg_q <= nxt;
    end

endmodule

// File: rtl/oep_buf_ptr.sv
module oep_buf_ptr #(
    parameter bit ISO_ALT = 1'b1
) (
    input  logic clk,
    input  logic rst,
    input  logic adv_nb,
    input  logic adv_iso,
    output logic nb_ptr,
    output logic iso_ptr
);

    always_ff @(posedge clk) begin
        if (rst)         nb_ptr <= 1'b0;
        else if (adv_nb) nb_ptr <= ~nb_ptr;
    end

    generate
        if (ISO_ALT) begin : g_iso_alt
            always_ff @(posedge clk) begin
                if (rst)          iso_ptr <= 1'b0;
                else if (adv_iso) iso_ptr <= ~iso_ptr;
            end
        end else begin : g_iso_fixed
            assign iso_ptr = 1'b0;
        end
    endgenerate

endmodule

// File: rtl/usb_out_ep_ctrl.sv
module usb_out_ep_ctrl
    import oep_pkg::*;
#(
    parameter int LEN_W   = 8,
    parameter bit IS_CTRL = 1'b1,
    parameter bit ISO_ALT = 1'b1
) (
    input  logic             clk,
    input  logic             rst,
    input  logic             cfg_wr,
    input  logic [7:0]       cfg_wdata,
    output logic [7:0]       cfg_rdata,
    input  logic             pkt_valid,
    input  logic             pkt_setup,
    input  logic             pkt_data1,
    input  logic [LEN_W-1:0] pkt_len,
    input  logic [LEN_W-1:0] ctrl_remain,
    input  logic             buf_full_x,
    input  logic             buf_full_y,
    output logic             hs_valid,
    output logic [1:0]       hs_code,
    output logic             rx_commit,
    output logic             rx_buf_y,
    output logic             irq,
    output logic [5:0]       iso_sample_bytes
);

    cfg_t cfg_q;
    dec_t dec;
    logic nb_ptr;
    logic iso_ptr;

    oep_decide #(.LEN_W(LEN_W), .IS_CTRL(IS_CTRL), .ISO_ALT(ISO_ALT)) u_dec (
        .cfg        (cfg_q),
        .pkt_valid  (pkt_valid),
        .pkt_setup  (pkt_setup),
        .pkt_data1  (pkt_data1),
        .pkt_len    (pkt_len),
        .ctrl_remain(ctrl_remain),
        .buf_full_x (buf_full_x),
        .buf_full_y (buf_full_y),
        .nb_ptr     (nb_ptr),
        .iso_ptr    (iso_ptr),
        .dec        (dec)
    );

    oep_cfg_reg u_cfg (
        .clk  (clk),
        .rst  (rst),
        .wr   (cfg_wr),
        .wdata(cfg_wdata),
        .dec  (dec),
        .cfg_q(cfg_q)
    );

    oep_buf_ptr #(.ISO_ALT(ISO_ALT)) u_ptr (
        .clk    (clk),
        .rst    (rst),
        .adv_nb (dec.adv_nb),
        .adv_iso(dec.adv_iso),
        .nb_ptr (nb_ptr),
        .iso_ptr(iso_ptr)
    );

    always_ff @(posedge clk) begin
        if (rst) begin
            hs_valid  <= 1'b0;
            hs_code   <= HS_NONE;
            rx_commit <= 1'b0;
            rx_buf_y  <= 1'b0;
            irq       <= 1'b0;
        end else begin
            hs_valid  <= (dec.code != HS_NONE);
            hs_code   <= dec.code;
            rx_commit <= dec.commit;
            rx_buf_y  <= dec.buf_y;
            irq       <= dec.irq;
        end
    end

    assign cfg_rdata        = cfg_view(cfg_q);
    assign iso_sample_bytes = cfg_q.iso ? ({1'b0, bps_field(cfg_q)} + 6'd1) : 6'd0;

endmodule

// File: rtl/oep_chk.sv
module oep_chk (
    input logic       clk,
    input logic       rst,
    input logic       cfg_wr,
    input logic       pkt_valid,
    input logic       pkt_setup,
    input logic [7:0] cfg_rdata,
    input logic       hs_valid,
    input logic [1:0] hs_code,
    input logic       rx_commit,
    input logic       rx_buf_y
);

    // R9
    iso_silent_chk: assert property (@(posedge clk) disable iff (rst)
        $past(pkt_valid && cfg_rdata[7:6] == 2'b11) |-> !hs_valid);

    // R2
    disabled_silent_chk: assert property (@(posedge clk) disable iff (rst)
        $past(pkt_valid && !cfg_rdata[7]) |-> (!hs_valid && !rx_commit));

    // R3
    stall_resp_chk: assert property (@(posedge clk) disable iff (rst)
        $past(pkt_valid && cfg_rdata[7:6] == 2'b10 && cfg_rdata[3] && !pkt_setup)
        |-> (hs_valid && hs_code == 2'd3));

    // R4
    resp_cause_chk: assert property (@(posedge clk) disable iff (rst)
        hs_valid |-> $past(pkt_valid));

    // R4
    commit_ack_chk: assert property (@(posedge clk) disable iff (rst)
        (rx_commit && $past(!cfg_rdata[6])) |-> (hs_valid && hs_code == 2'd1));

    // R7
    single_buf_chk: assert property (@(posedge clk) disable iff (rst)
        (rx_commit && $past(cfg_rdata[7:6] == 2'b10 && !cfg_rdata[4])) |-> !rx_buf_y);

    // R10
    ovf_sticky_chk: assert property (@(posedge clk) disable iff (rst)
        $past(cfg_rdata[7:6] == 2'b11 && cfg_rdata[5] && !cfg_wr) |-> cfg_rdata[5]);

endmodule

bind usb_out_ep_ctrl oep_chk u_chk (
    .clk      (clk),
    .rst      (rst),
    .cfg_wr   (cfg_wr),
    .pkt_valid(pkt_valid),
    .pkt_setup(pkt_setup),
    .cfg_rdata(cfg_rdata),
    .hs_valid (hs_valid),
    .hs_code  (hs_code),
    .rx_commit(rx_commit),
    .rx_buf_y (rx_buf_y)
);

// File: tb/usb_out_ep_ctrl_test.sv
module usb_out_ep_ctrl_test;

    logic       clk = 1'b0;
    logic       rst = 1'b1;
    logic       cfg_wr = 1'b0;
    logic [7:0] cfg_wdata = '0;
    logic [7:0] cfg_rdata;
    logic       pkt_valid = 1'b0;
    logic       pkt_setup = 1'b0;
    logic       pkt_data1 = 1'b0;
    logic [7:0] pkt_len = '0;
    logic [7:0] ctrl_remain = '0;
    logic       buf_full_x = 1'b0;
    logic       buf_full_y = 1'b0;
    logic       hs_valid;
    logic [1:0] hs_code;
    logic       rx_commit;
    logic       rx_buf_y;
    logic       irq;
    logic [5:0] iso_sample_bytes;

    int checks = 0;
    int fails  = 0;
    bit done   = 1'b0;

    always #5 clk = ~clk;

    usb_out_ep_ctrl uut (.*);

    typedef struct packed {
        logic       wr;
        logic [7:0] wd;
        logic       st;
        logic       d1;
        logic [7:0] len;
        logic [7:0] rem;
        logic       fx;
        logic       fy;
        logic       ehv;
        logic [1:0] ecode;
        logic       ecom;
        logic       eby;
        logic       eirq;
        logic [7:0] ecfg;
        logic [7:0] req;
    } vec_t;

    localparam int NV = 21;
    localparam vec_t VECS [NV] = '{
        '{1'b1, 8'h84, 1'b0, 1'b0, 8'd8,  8'd64, 1'b0, 1'b0, 1'b1, 2'd1, 1'b1, 1'b0, 1'b1, 8'hA4, 8'd4},  // R4
        '{1'b0, 8'h00, 1'b0, 1'b1, 8'd8,  8'd64, 1'b0, 1'b0, 1'b1, 2'd1, 1'b1, 1'b0, 1'b1, 8'h84, 8'd4},  // R4
        '{1'b0, 8'h00, 1'b0, 1'b1, 8'd8,  8'd64, 1'b0, 1'b0, 1'b1, 2'd1, 1'b0, 1'b0, 1'b0, 8'h84, 8'd5},  // R5
        '{1'b0, 8'h00, 1'b0, 1'b0, 8'd8,  8'd64, 1'b1, 1'b0, 1'b1, 2'd2, 1'b0, 1'b0, 1'b0, 8'h84, 8'd6},  // R6
        '{1'b1, 8'h94, 1'b0, 1'b0, 8'd8,  8'd64, 1'b0, 1'b0, 1'b1, 2'd1, 1'b1, 1'b0, 1'b1, 8'hB4, 8'd7},  // R7
        '{1'b0, 8'h00, 1'b0, 1'b1, 8'd8,  8'd64, 1'b0, 1'b0, 1'b1, 2'd1, 1'b1, 1'b1, 1'b1, 8'h94, 8'd7},  // R7
        '{1'b0, 8'h00, 1'b0, 1'b0, 8'd8,  8'd64, 1'b0, 1'b1, 1'b1, 2'd1, 1'b1, 1'b0, 1'b1, 8'hB4, 8'd7},  // R7
        '{1'b0, 8'h00, 1'b0, 1'b1, 8'd8,  8'd64, 1'b0, 1'b1, 1'b1, 2'd2, 1'b0, 1'b0, 1'b0, 8'hB4, 8'd6},  // R6
        '{1'b1, 8'h8C, 1'b0, 1'b0, 8'd8,  8'd64, 1'b0, 1'b0, 1'b1, 2'd3, 1'b0, 1'b0, 1'b0, 8'h8C, 8'd3},  // R3
        '{1'b0, 8'h00, 1'b1, 1'b0, 8'd8,  8'd64, 1'b1, 1'b0, 1'b1, 2'd1, 1'b1, 1'b0, 1'b1, 8'hAC, 8'd3},  // R3
        '{1'b1, 8'h84, 1'b0, 1'b1, 8'd20, 8'd16, 1'b0, 1'b0, 1'b1, 2'd3, 1'b0, 1'b0, 1'b1, 8'h8C, 8'd8},  // R8
        '{1'b1, 8'h80, 1'b0, 1'b0, 8'd20, 8'd16, 1'b0, 1'b0, 1'b1, 2'd3, 1'b0, 1'b0, 1'b1, 8'h88, 8'd8},  // R8
        '{1'b1, 8'h84, 1'b0, 1'b0, 8'd8,  8'd8,  1'b0, 1'b0, 1'b1, 2'd1, 1'b1, 1'b0, 1'b1, 8'hA4, 8'd8},  // R8
        '{1'b1, 8'h04, 1'b0, 1'b0, 8'd8,  8'd64, 1'b0, 1'b0, 1'b0, 2'd0, 1'b0, 1'b0, 1'b0, 8'h04, 8'd2},  // R2
        '{1'b1, 8'h87, 1'b0, 1'b0, 8'd8,  8'd64, 1'b0, 1'b0, 1'b1, 2'd1, 1'b1, 1'b0, 1'b1, 8'hA4, 8'd12}, // R12
        '{1'b1, 8'hC3, 1'b0, 1'b0, 8'd8,  8'd64, 1'b0, 1'b0, 1'b0, 2'd0, 1'b1, 1'b0, 1'b0, 8'hC3, 8'd9},  // R9
        '{1'b0, 8'h00, 1'b0, 1'b0, 8'd8,  8'd64, 1'b0, 1'b0, 1'b0, 2'd0, 1'b1, 1'b1, 1'b0, 8'hC3, 8'd9},  // R9
        '{1'b0, 8'h00, 1'b0, 1'b0, 8'd8,  8'd64, 1'b1, 1'b0, 1'b0, 2'd0, 1'b0, 1'b0, 1'b0, 8'hE3, 8'd10}, // R10
        '{1'b1, 8'hE3, 1'b0, 1'b0, 8'd8,  8'd64, 1'b0, 1'b0, 1'b0, 2'd0, 1'b1, 1'b0, 1'b0, 8'hE3, 8'd10}, // R10
        '{1'b1, 8'hC3, 1'b0, 1'b0, 8'd8,  8'd64, 1'b0, 1'b1, 1'b0, 2'd0, 1'b0, 1'b0, 1'b0, 8'hE3, 8'd10}, // R10
        '{1'b1, 8'hC3, 1'b0, 1'b0, 8'd8,  8'd64, 1'b0, 1'b0, 1'b0, 2'd0, 1'b1, 1'b1, 1'b0, 8'hC3, 8'd10}  // R10
    };

    task automatic check(input bit ok, input int req, input string what,
                         input int act, input int exp);
        checks++;
        if (!ok) begin
            fails++;
            $display("FAIL R%0d %s actual=0x%0h expected=0x%0h", req, what, act, exp);
        end
    endtask

    task automatic cfg_write(input logic [7:0] d);
        @(negedge clk);
        cfg_wr    = 1'b1;
        cfg_wdata = d;
        @(negedge clk);
        cfg_wr    = 1'b0;
    endtask

    initial begin
        repeat (100000) @(posedge clk);
        if (!done) begin
            fails++;
            $display("FAIL watchdog expired");
            $display("TB_RESULT checks=%0d failures=%0d", checks, fails);
            $finish;
        end
    end

    initial begin
        // R1: reset state
        repeat (3) @(negedge clk);
        rst = 1'b0;
        @(negedge clk);
        check(cfg_rdata == 8'h00, 1, "reset cfg", cfg_rdata, 0);
        check(!hs_valid && !rx_commit && !irq, 1, "reset outputs",
              {hs_valid, rx_commit, irq}, 0);
        check(iso_sample_bytes == 6'd0, 1, "reset sample bytes", iso_sample_bytes, 0);

        for (int i = 0; i < NV; i++) begin
            @(negedge clk);
            cfg_wr    = VECS[i].wr;
            cfg_wdata = VECS[i].wd;
            @(negedge clk);
            cfg_wr      = 1'b0;
            pkt_setup   = VECS[i].st;
            pkt_data1   = VECS[i].d1;
            pkt_len     = VECS[i].len;
            ctrl_remain = VECS[i].rem;
            buf_full_x  = VECS[i].fx;
            buf_full_y  = VECS[i].fy;
            pkt_valid   = 1'b1;
            @(negedge clk);
            pkt_valid = 1'b0;
            check(hs_valid == VECS[i].ehv && hs_code == VECS[i].ecode, int'(VECS[i].req),
                  $sformatf("vec %0d handshake", i), {hs_valid, hs_code},
                  {VECS[i].ehv, VECS[i].ecode});
            check(rx_commit == VECS[i].ecom && (!VECS[i].ecom || rx_buf_y == VECS[i].eby),
                  int'(VECS[i].req), $sformatf("vec %0d commit/buffer", i),
                  {rx_commit, rx_buf_y}, {VECS[i].ecom, VECS[i].eby});
            check(irq == VECS[i].eirq, int'(VECS[i].req), $sformatf("vec %0d irq", i),
                  irq, VECS[i].eirq);
            check(cfg_rdata == VECS[i].ecfg, int'(VECS[i].req), $sformatf("vec %0d cfg", i),
                  cfg_rdata, VECS[i].ecfg);
        end
        buf_full_x = 1'b0;
        buf_full_y = 1'b0;

        // R10: clearing write and overflow in the same cycle, set wins
        // cfg is 0xC3 and the isochronous pointer is back on X here
        @(negedge clk);
        cfg_wr     = 1'b1;
        cfg_wdata  = 8'hC3;
        buf_full_x = 1'b1;
        pkt_valid  = 1'b1;
        @(negedge clk);
        cfg_wr     = 1'b0;
        pkt_valid  = 1'b0;
        buf_full_x = 1'b0;
        check(cfg_rdata == 8'hE3, 10, "clear vs set same cycle", cfg_rdata, 8'hE3);
        check(!rx_commit && !hs_valid, 10, "overflow no commit", {rx_commit, hs_valid}, 0);

        // R11: bytes per sample decoding
        cfg_write(8'hC3);
        check(iso_sample_bytes == 6'd4, 11, "bps 3", iso_sample_bytes, 4);
        cfg_write(8'hC0);
        check(iso_sample_bytes == 6'd1, 11, "bps 0", iso_sample_bytes, 1);
        cfg_write(8'hDF);
        check(iso_sample_bytes == 6'd32, 11, "bps 31", iso_sample_bytes, 32);
        cfg_write(8'h9F);
        check(iso_sample_bytes == 6'd0, 11, "non-iso bps", iso_sample_bytes, 0);
        // R12: reserved bits masked
        check(cfg_rdata == 8'h9C, 12, "reserved read", cfg_rdata, 8'h9C);

        done = 1'b1;
        $display("TB_RESULT checks=%0d failures=%0d", checks, fails);
        $finish;
    end

endmodule